// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Sequencer

This block lets a processor read serial flash as if it were ordinary memory. While its mapping enable is set, every read request on its ready/valid port becomes one complete flash transaction: chip select falls, an optional command byte goes out, then the low-order address bytes, then a run of dummy clocks that carry a pad byte, and finally four data bytes are shifted in. The block packs those bytes into a 32-bit word, returns it on the response port and releases chip select. A single format register sets the shape of the transaction. It holds the command enable, the opcode, the address length, the dummy count, the pad byte and a separate lane width (one, two or four lanes) for the command, address and data phases.

Clearing the mapping enable hands the flash pins to a software-driven serial engine, whose chip select, clock and data lines enter on the sw* inputs and pass straight to the pins. The handover waits for any transaction in flight to finish. A mapped read that arrives while the enable is clear gets an error response and leaves the pins alone.

Top module: `xip_read_seq`

## Requirements
- R1: After reset the mapping enable is 1, chip select is high, SCK is low, no data lane is driven, reqReady is 1 and the format is: command enabled, opcode 0x03, three address bytes, no dummy cycles, single lane in every phase.
- R2: A configuration write to offset 0x60 sets the mapping enable from data bit 0. A write to offset 0x64 loads the format register. Writes to any other offset change nothing.
- R3: Format fields: bit 0 is the command enable, bits [3:1] the address byte count, bits [7:4] the dummy cycle count, bits [9:8] the command lane code, bits [11:10] the address lane code, bits [13:12] the data lane code, bits [23:16] the opcode and bits [31:24] the pad byte. An accepted request pulls chip select low on the next cycle. It then runs its beats in the order command, address, dummy, data. Each beat is one clock low followed by one clock high of SCK, and the flash samples on the rising edge. The response appears 2*beats+1 cycles after acceptance.
- R4: When enabled, the command phase sends the 8-bit opcode most significant bit first. When the command enable is 0 the phase is skipped.
- R5: The address phase sends the N lowest bytes of the request address, most significant bit first. A count above 3 is treated as 3, and a count of 0 skips the phase.
- R6: The dummy phase lasts exactly the dummy count in beats. It shifts out the pad byte, most significant bit first and followed by zeros, on the address-phase lanes.
- R7: Lane code 0 is single lane: data out on lane 0, data in on lane 1, one bit per beat. Code 1 is dual: lanes 1:0, two bits per beat. Code 2 is quad: lanes 3:0, four bits per beat. Code 3 acts as single lane. The higher-numbered lane carries the earlier bit. Only the lanes in use are driven, and no lane is driven during the data phase.
- R8: The four received bytes form the response little-endian: the first byte goes to bits [7:0]. rspValid pulses for one cycle with rspErr low, while chip select is already high.
- R9: A request accepted while the enable is 0 gets rspValid with rspErr high on the next cycle. The pins keep following the software inputs and no SCK edge is produced.
- R10: Clearing the enable during a transaction lets that transaction finish with correct data. swOwner stays 0 until the engine is idle and rises the cycle after the response.
- R11: reqReady is low from acceptance until the engine has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration register offset |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Read request accepted when high with reqValid |
| reqAddr | input | 24 | Flash byte address of the request |
| rspValid | output | 1 | Response valid, one-cycle pulse |
| rspErr | output | 1 | Response is an error (mapping disabled) |
| rspData | output | 32 | Read word |
| swOwner | output | 1 | Software engine owns the pins |
| swCsN | input | 1 | Software chip select |
| swSck | input | 1 | Software serial clock |
| swDq | input | 4 | Software data out per lane |
| swDqOe | input | 4 | Software output enable per lane |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Flash serial clock |
| dqOut | output | 4 | Data lane output values |
| dqOe | output | 4 | Data lane output enables |
| dqIn | input | 4 | Data lane input values |

## Verification
The two functions that can fall in the same cycle are a software write that clears the mapping enable and a mapped read still on the wire. The bench starts a read and clears the enable a few cycles into it, while the command and address beats are still running. It judges the outcome by three things: the returned word equals the byte-swapped flash stream, swOwner stays low on every cycle up to the response, and the pins follow the software inputs on the cycle after. A further read issued after the handover must then come back as an error without any SCK edge.

// File: rtl/xip_pkg.sv
package xip_pkg;
  localparam int ADDR_BYTES_MAX = 3;
  localparam int WORD_BYTES     = 4;
  localparam int ADDR_W         = 8 * ADDR_BYTES_MAX;
  localparam int WORD_W         = 8 * WORD_BYTES;
  localparam int SHIFT_W        = WORD_W;
  localparam int LANES          = 4;
  localparam int CNT_W          = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_PAD, PH_DATA, PH_DONE
  } phase_e;

  // format register contents without the two unused bits [15:14]
  typedef struct packed {
    logic [7:0] padCode;
    logic [7:0] cmdCode;
    logic [1:0] dataProto;
    logic [1:0] addrProto;
    logic [1:0] cmdProto;
    logic [3:0] padCnt;
    logic [2:0] addrBytes;
    logic       cmdEn;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{padCode: 8'h00, cmdCode: 8'h03, dataProto: 2'd0,
                                 addrProto: 2'd0, cmdProto: 2'd0, padCnt: 4'd0,
                                 addrBytes: 3'd3, cmdEn: 1'b1};

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    phase_e     phase;
    logic       shift;
    logic       capture;
    logic       drive;
    logic [1:0] proto;
    logic [7:0] cmdCode;
    logic [7:0] padCode;
    logic [1:0] addrN;
  } dp_ctl_t;

  function automatic int laneShift(input logic [1:0] proto);
    case (proto)
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int addrCount(input fmt_t f);
    return (int'(f.addrBytes) > ADDR_BYTES_MAX) ? ADDR_BYTES_MAX : int'(f.addrBytes);
  endfunction
endpackage

// File: rtl/xip_ctrl.sv
module xip_ctrl
  import xip_pkg::*;
#(
  parameter int          REG_AW   = 8,
  parameter logic [7:0]  CTRL_OFS = 8'h60,
  parameter logic [7:0]  FMT_OFS  = 8'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspErr,
  output logic [ADDR_W-1:0] addrUse,
  output dp_ctl_t           dpCtl,
  output logic              engCsN,
  output logic              engSck,
  output logic              swOwner
);
  phase_e            state;
  logic              half;
  logic [CNT_W-1:0]  cnt;
  logic              enReg;
  logic              errPulse;
  fmt_t              fmtReg, fmtLat, fmtUse;
  logic [ADDR_W-1:0] addrLat;
  phase_e            firstPh, nxtPh;
  logic              active;
  logic              unusedBits;

  assign unusedBits = ^cfgWrData[15:14];

  function automatic phase_e phaseAfter(input phase_e p, input fmt_t f);
    if (p == PH_IDLE && f.cmdEn) return PH_CMD;
    if ((p == PH_IDLE || p == PH_CMD) && addrCount(f) != 0) return PH_ADDR;
    if (p != PH_PAD && p != PH_DATA && f.padCnt != 4'd0) return PH_PAD;
    if (p == PH_DATA) return PH_DONE;
    return PH_DATA;
  endfunction

  function automatic logic [1:0] protoOf(input phase_e p, input fmt_t f);
    case (p)
      PH_CMD:          return f.cmdProto;
      PH_ADDR, PH_PAD: return f.addrProto;
      default:         return f.dataProto;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] beatsOf(input phase_e p, input fmt_t f);
    case (p)
      PH_CMD:  return CNT_W'(8 >> laneShift(f.cmdProto));
      PH_ADDR: return CNT_W'((8 * addrCount(f)) >> laneShift(f.addrProto));
      PH_PAD:  return CNT_W'(f.padCnt);
      default: return CNT_W'(WORD_W >> laneShift(f.dataProto));
    endcase
  endfunction

  assign firstPh = phaseAfter(PH_IDLE, fmtReg);
  assign nxtPh   = phaseAfter(state, fmtLat);
  assign active  = (state == PH_CMD) || (state == PH_ADDR) || (state == PH_PAD) || (state == PH_DATA);
  assign fmtUse  = (state == PH_IDLE) ? fmtReg : fmtLat;
  assign addrUse = (state == PH_IDLE) ? reqAddr : addrLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      half     <= 1'b0;
      cnt      <= '0;
      enReg    <= 1'b1;
      errPulse <= 1'b0;
      fmtReg   <= FMT_RESET;
      fmtLat   <= FMT_RESET;
      addrLat  <= '0;
    end else begin
      errPulse <= 1'b0;
      if (cfgWrEn && cfgAddr == CTRL_OFS) enReg <= cfgWrData[0];
      if (cfgWrEn && cfgAddr == FMT_OFS) fmtReg <= {cfgWrData[31:16], cfgWrData[13:0]};
      case (state)
        PH_IDLE: begin
          if (reqValid && enReg) begin
            state   <= firstPh;
            cnt     <= beatsOf(firstPh, fmtReg) - 1'b1;
            fmtLat  <= fmtReg;
            addrLat <= reqAddr;
            half    <= 1'b0;
          end else if (reqValid) begin
            errPulse <= 1'b1;
          end
        end
        PH_DONE: state <= PH_IDLE;
        default: begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              state <= nxtPh;
              cnt   <= beatsOf(nxtPh, fmtLat) - 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    dpCtl.load    = (state == PH_IDLE && reqValid && enReg) || (active && half && cnt == '0);
    dpCtl.phase   = (state == PH_IDLE) ? firstPh : nxtPh;
    dpCtl.shift   = active && half && cnt != '0;
    dpCtl.capture = (state == PH_DATA) && half;
    dpCtl.drive   = (state == PH_CMD) || (state == PH_ADDR) || (state == PH_PAD);
    dpCtl.proto   = protoOf(state, fmtLat);
    dpCtl.cmdCode = fmtUse.cmdCode;
    dpCtl.padCode = fmtUse.padCode;
    dpCtl.addrN   = 2'(addrCount(fmtUse));
  end

  assign reqReady = (state == PH_IDLE);
  assign rspValid = (state == PH_DONE) || errPulse;
  assign rspErr   = errPulse;
  assign engCsN   = !active;
  assign engSck   = active && half;
  assign swOwner  = !enReg && (state == PH_IDLE);
endmodule

// File: rtl/xip_datapath.sv
module xip_datapath
  import xip_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           dpCtl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  dqIn,
  output logic [LANES-1:0]  dqOut,
  output logic [LANES-1:0]  dqOe,
  output logic [WORD_W-1:0] rxWord
);
  logic [SHIFT_W-1:0] tx;
  logic [WORD_W-1:0]  rx;
  logic [WORD_W-1:0]  sample;
  int                 laneW;

  assign laneW = 1 << laneShift(dpCtl.proto);

  always_comb begin
    case (laneShift(dpCtl.proto))
      1: begin
        sample = WORD_W'(dqIn[1:0]);
        dqOut  = {2'b00, tx[SHIFT_W-1 -: 2]};
        dqOe   = 4'b0011;
      end
      2: begin
        sample = WORD_W'(dqIn);
        dqOut  = tx[SHIFT_W-1 -: 4];
        dqOe   = 4'b1111;
      end
      default: begin
        sample = WORD_W'(dqIn[1]);
        dqOut  = {3'b000, tx[SHIFT_W-1]};
        dqOe   = 4'b0001;
      end
    endcase
    if (!dpCtl.drive) dqOe = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (dpCtl.load) begin
        case (dpCtl.phase)
          PH_CMD:  tx <= {dpCtl.cmdCode, (SHIFT_W-8)'(0)};
          PH_ADDR: tx <= {addr, (SHIFT_W-ADDR_W)'(0)} << (8 * (ADDR_BYTES_MAX - int'(dpCtl.addrN)));
          PH_PAD:  tx <= {dpCtl.padCode, (SHIFT_W-8)'(0)};
          default: tx <= tx;
        endcase
      end else if (dpCtl.shift) begin
        tx <= tx << laneW;
      end
      if (dpCtl.capture) rx <= (rx << laneW) | sample;
    end
  end

  // first byte on the wire becomes the least significant byte
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
    assign rxWord[8*b +: 8] = rx[WORD_W-8*(b+1) +: 8];
  end
endmodule

// File: rtl/xip_read_seq.sv
module xip_read_seq
  import xip_pkg::*;
#(
  parameter int         REG_AW   = 8,
  parameter logic [7:0] CTRL_OFS = 8'h60,
  parameter logic [7:0] FMT_OFS  = 8'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspErr,
  output logic [WORD_W-1:0] rspData,
  output logic              swOwner,
  input  logic              swCsN,
  input  logic              swSck,
  input  logic [LANES-1:0]  swDq,
  input  logic [LANES-1:0]  swDqOe,
  output logic              csN,
  output logic              sck,
  output logic [LANES-1:0]  dqOut,
  output logic [LANES-1:0]  dqOe,
  input  logic [LANES-1:0]  dqIn
);
  dp_ctl_t           dpCtl;
  logic [ADDR_W-1:0] addrUse;
  logic              engCsN, engSck;
  logic [LANES-1:0]  engDq, engOe;

  xip_ctrl #(.REG_AW(REG_AW), .CTRL_OFS(CTRL_OFS), .FMT_OFS(FMT_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspErr(rspErr), .addrUse(addrUse), .dpCtl(dpCtl),
    .engCsN(engCsN), .engSck(engSck), .swOwner(swOwner)
  );

  xip_datapath u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .addr(addrUse), .dqIn(dqIn),
    .dqOut(engDq), .dqOe(engOe), .rxWord(rspData)
  );

  assign csN   = swOwner ? swCsN  : engCsN;
  assign sck   = swOwner ? swSck  : engSck;
  assign dqOut = swOwner ? swDq   : engDq;
  assign dqOe  = swOwner ? swDqOe : engOe;
endmodule

// File: rtl/xip_read_chk.sv
module xip_read_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic rspErr,
  input logic csN,
  input logic sck,
  input logic swOwner
);
  assert_err_is_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  assert_err_next_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && swOwner) |=> (rspValid && rspErr));

  assert_cs_on_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !swOwner) |=> !csN);

  assert_rsp_cs_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> csN);

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !swOwner) |-> !sck);

  assert_handover_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swOwner) |-> $past(csN));

  assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !swOwner) |-> !reqReady);
endmodule

bind xip_read_seq xip_read_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspErr(rspErr), .csN(csN), .sck(sck), .swOwner(swOwner)
);

// File: tb/xip_read_seq_tb.sv
module xip_read_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        rspValid, rspErr, swOwner, csN, sck;
  logic [31:0] rspData;
  logic        swCsN = 1'b1, swSck = 1'b0;
  logic [3:0]  swDq = 4'b1010, swDqOe = 4'b0110;
  logic [3:0]  dqOut, dqOe, dqIn;

  int checks = 0, fails = 0;
  bit done = 0;

  xip_read_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData), .swOwner(swOwner),
    .swCsN(swCsN), .swSck(swSck), .swDq(swDq), .swDqOe(swDqOe),
    .csN(csN), .sck(sck), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model: records driven beats, returns a data stream
  logic [3:0]  capOe [0:127];
  logic [3:0]  capDq [0:127];
  logic [3:0]  expOe [0:127];
  logic [3:0]  expDq [0:127];
  int          posCnt = 0, negCnt = 0, expN = 0, dataStart = 0, dataLanes = 1;
  logic [31:0] streamWord = '0;
  logic [31:0] curFmt = 32'h0003_0007;
  int          kBeat;
  logic [31:0] vIn;

  always @(posedge sck) if (!csN) begin
    capOe[posCnt] = dqOe;
    capDq[posCnt] = dqOut & dqOe;
    posCnt++;
  end
  always @(negedge sck) if (!csN) negCnt++;

  always @* begin
    kBeat = negCnt - dataStart;
    dqIn  = 4'b0000;
    if (!csN && kBeat >= 0) begin
      vIn = streamWord << (kBeat * dataLanes);
      case (dataLanes)
        2:       dqIn = {2'b00, vIn[31:30]};
        4:       dqIn = vIn[31:28];
        default: dqIn = {2'b00, vIn[31], 1'b0};
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int laneW(input logic [1:0] p);
    return (p == 2'd1) ? 2 : (p == 2'd2) ? 4 : 1;
  endfunction

  task automatic pushBeat(input int L, input logic [31:0] v, input bit drive);
    logic [3:0] d, m;
    case (L)
      2:       begin d = {2'b00, v[31:30]}; m = 4'b0011; end
      4:       begin d = v[31:28];          m = 4'b1111; end
      default: begin d = {3'b000, v[31]};   m = 4'b0001; end
    endcase
    if (!drive) m = 4'b0000;
    expOe[expN] = m;
    expDq[expN] = d & m;
    expN++;
  endtask

  // expected beat list from the format fields in R3..R7
  task automatic buildExp(input logic [23:0] a);
    int n, lc, la, ld;
    n  = (curFmt[3:1] > 3'd3) ? 3 : int'(curFmt[3:1]);
    lc = laneW(curFmt[9:8]);
    la = laneW(curFmt[11:10]);
    ld = laneW(curFmt[13:12]);
    expN = 0;
    if (curFmt[0])
      for (int i = 0; i < 8 / lc; i++) pushBeat(lc, {curFmt[23:16], 24'h0} << (i * lc), 1'b1);
    for (int i = 0; i < (8 * n) / la; i++)
      pushBeat(la, ({a, 8'h0} << (8 * (3 - n))) << (i * la), 1'b1);
    for (int i = 0; i < int'(curFmt[7:4]); i++) pushBeat(la, {curFmt[31:24], 24'h0} << (i * la), 1'b1);
    dataStart = expN;
    dataLanes = ld;
    for (int i = 0; i < 32 / ld; i++) pushBeat(ld, 32'h0, 1'b0);
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 8'h64) curFmt = d;
  endtask

  task automatic doRead(input logic [23:0] a, input logic [31:0] stream, input bit dis,
                        input bit expErr, input string tag);
    int iter, bad;
    bit got, er, ownerSeen, rdyBad;
    logic [31:0] rd, expWord;
    posCnt = 0; negCnt = 0; streamWord = stream;
    buildExp(a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(posedge clk);
    iter = 0; got = 0; ownerSeen = 0; rdyBad = 0; er = 0; rd = '0;
    while (!got && iter < 4000) begin
      @(negedge clk);
      iter++;
      if (iter == 1) reqValid = 1'b0;
      if (dis && iter == 6) begin cfgWrEn = 1'b1; cfgAddr = 8'h60; cfgWrData = 32'h0; end
      if (dis && iter == 7) cfgWrEn = 1'b0;
      if (rspValid) begin
        got = 1; rd = rspData; er = rspErr;
      end else begin
        if (swOwner) ownerSeen = 1;
      end
      if (reqReady && !expErr) rdyBad = 1;
    end
    if (expErr) begin
      check(got && er && iter == 1, "R9 error response", {31'h0, er}, 32'h1);
      check(posCnt == 0, "R9 no SCK edge", posCnt, 0);
      check(csN == swCsN && dqOut == swDq && dqOe == swDqOe, "R9 pins follow software",
            {csN, dqOut, dqOe}, {swCsN, swDq, swDqOe});
    end else begin
      expWord = {stream[7:0], stream[15:8], stream[23:16], stream[31:24]};
      check(got && !er, {tag, "/R8 response ok"}, {31'h0, er}, 32'h0);
      check(rd == expWord, {tag, "/R8 little-endian word"}, rd, expWord);
      check(posCnt == expN, {tag, "/R3 beat count"}, posCnt, expN);
      check(iter == 2 * expN + 1, {tag, "/R3 latency"}, iter, 2 * expN + 1);
      bad = 0;
      for (int i = 0; i < expN && i < posCnt; i++)
        if (capOe[i] != expOe[i] || capDq[i] != expDq[i]) bad++;
      check(bad == 0, {tag, "/R7 beat contents"}, bad, 0);
      check(!rdyBad, "R11 ready low while busy", {31'h0, rdyBad}, 0);
      if (dis) begin
        check(!ownerSeen, "R10 pins held until idle", {31'h0, ownerSeen}, 0);
        @(negedge clk);
        check(swOwner && csN == swCsN, "R10 handover after response", {31'h0, swOwner}, 1);
      end
    end
  endtask

  task automatic testReset;
    check(csN == 1'b1 && sck == 1'b0 && dqOe == 4'b0, "R1 idle pins", {csN, sck, dqOe}, 6'b100000);
    check(reqReady && !rspValid, "R1 ready idle", {reqReady, rspValid}, 2'b10);
    check(!swOwner, "R1 enable set", {31'h0, swOwner}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R1 default format, R4 opcode, R5 three bytes
    doRead(24'h123456, 32'hA1B2C3D4, 0, 0, "R4");
    // R6 pad with quad address/data, single command
    cfgWrite(8'h64, 32'hA5EB_2841);
    doRead(24'h00ABCD, 32'h5A6B7C8D, 0, 0, "R6");
    // R4 command skipped, R5 one address byte, dual lanes
    cfgWrite(8'h64, 32'h0000_1402);
    doRead(24'hFFFF7E, 32'h0F1E2D3C, 0, 0, "R5");
    // R5 count 7 clamps to 3; R7 lane code 3 acts single; pad 3
    cfgWrite(8'h64, 32'hC30B_033F);
    doRead(24'h89ABCD, 32'hDEADBEEF, 0, 0, "R7");
    // R2 write to another offset changes nothing
    cfgWrite(8'h68, 32'h0);
    check(!swOwner, "R2 other offset ignored", {31'h0, swOwner}, 0);
    doRead(24'h000001, 32'h01020304, 0, 0, "R2");
    // R9 disabled read
    cfgWrite(8'h60, 32'h0);
    check(swOwner, "R2 enable cleared", {31'h0, swOwner}, 1);
    doRead(24'h000010, 32'h0, 0, 1, "R9");
    // R10 clear enable mid transaction
    cfgWrite(8'h60, 32'h1);
    cfgWrite(8'h64, 32'h0003_0007);
    doRead(24'h345678, 32'h11223344, 1, 0, "R10");
    doRead(24'h000020, 32'h0, 0, 1, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule